// File: doc/BRIEF.md
# Serial Register Port for a Converter

This block is the serial-side front end of a data converter's register file. It sits idle until a command byte arrives. The command byte names one target register, gives the direction of the transfer and picks one of three calibration channel pairs. The block then moves exactly as many bits as the target holds, most significant bit first, and goes back to waiting for the next command byte. Each serial bit arrives as a one-cycle `shiftEn` strobe in the system clock domain, with `sdi` valid alongside it. The block ignores the strobe while `csN` is high.

The block stores an 8-bit test register and three independent pairs of 24-bit calibration registers. Each pair has one offset register and one gain register. The conversion result comes from the analog side on `convData` and can only be read. A write aimed at that result must still be clocked in full, and its bits are then dropped. Raising `csN` in the middle of a transfer abandons it. A run of consecutive ones on `sdi` puts the bit framing back at the start of a command byte. A calibration access made while the analog side reports a calibration in progress is refused, and that refusal is remembered in a sticky flag.

Top module: `adc_serial_regif`

## Requirements
- R1: After reset, `sdo`, `testMode` and `calErr` are 0. The test register reads 0x00, every offset register reads 0x1F4000 and every gain register reads 0x5761AB.
- R2: A command byte is 8 accepted bits, sent MSB first. Bit 7 must be 0, or the byte is ignored. Bits 6:4 select the target: 100 is the test register, 101 the result, 110 an offset register and 111 a gain register. Bit 3 set means read and clear means write. Bits 1:0 select the pair. Select codes 000 to 011 start no transfer.
- R3: On a read, the register's first bit (its MSB) appears on `sdo` right after the clock edge that accepts the eighth command bit. Each later accepted bit moves `sdo` on by one bit. A calibration read is 24 bits and a test read is 8 bits. A result read is 24 bits of `convData` when `wordLen24` is 1, and 16 bits (`convData[23:8]`) when it is 0. `wordLen24` is sampled when the command byte completes. Outside a read, `sdo` is 0.
- R4: A calibration write updates only the addressed register, and only on the edge that accepts its 24th data bit. Pair code 3 addresses pair 2. No other register changes.
- R5: A write to the result register consumes 16 or 24 bits, according to `wordLen24`, and changes nothing. The block then waits for a command byte.
- R6: `csN` high abandons any transfer or partial command byte without changing any register.
- R7: On the 32nd consecutive accepted 1 bit, the block goes back to waiting for the first bit of a command byte.
- R8: `testMode` is 1 exactly when the test register is nonzero. Only reset, or a complete test-register write, changes it.
- R9: A calibration command byte that arrives while `calBusy` is 1 starts no transfer and sets `calErr`. `calErr` stays set until reset.
- R10: `shiftEn` strobes while `csN` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; high abandons the transfer |
| shiftEn | input | 1 | One-cycle strobe per serial bit |
| sdi | input | 1 | Serial data in, valid with `shiftEn` |
| sdo | output | 1 | Serial data out |
| wordLen24 | input | 1 | Result word length: 1 = 24 bits, 0 = 16 bits |
| calBusy | input | 1 | A calibration is running on the analog side |
| convData | input | 24 | Latest conversion result |
| testMode | output | 1 | Test register is nonzero |
| calErr | output | 1 | Sticky flag for a refused calibration access |

## Verification
Every result is due a fixed number of edges after the strobe that causes it. A read's first bit is on `sdo` one edge after the eighth command bit, and each further bit follows one edge after the next strobe. A register update, or a change on `testMode`, shows one edge after the last data bit. `calErr` rises one edge after the refused command byte. The bench drives inputs on the falling edge and samples outputs on the falling edge after the capturing edge. A behavioural model follows the same strobes, and its view of `sdo`, `testMode` and `calErr` is compared on every falling edge. Read-back checks confirm each stored value and check that the framing has not drifted.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } ifState_t;

  localparam logic [2:0] SEL_TEST = 3'b100;
  localparam logic [2:0] SEL_DATA = 3'b101;
  localparam logic [2:0] SEL_ZS   = 3'b110;
  localparam logic [2:0] SEL_FS   = 3'b111;

  typedef struct packed {
    logic       loadRead;
    logic       shiftOut;
    logic       shiftIn;
    logic       commitTest;
    logic       commitZs;
    logic       commitFs;
    logic [2:0] sel;
    logic [1:0] pair;
  } dpCtl_t;
endpackage

// File: rtl/adc_if_ctrl.sv
module adc_if_ctrl
  import adc_if_pkg::*;
#(
  parameter int CAL_W      = 24,
  parameter int SHORT_W    = 16,
  parameter int TEST_W     = 8,
  parameter int ONES_LIMIT = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   csN,
  input  logic   shiftEn,
  input  logic   sdi,
  input  logic   wordLen24,
  input  logic   calBusy,
  output dpCtl_t ctl,
  output logic   reading,
  output logic   calErr
);
  localparam int CNT_W  = $clog2(CAL_W + 1);
  localparam int ONES_W = $clog2(ONES_LIMIT);
  localparam logic [CNT_W-1:0] LEN_CAL   = CNT_W'(CAL_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);
  localparam logic [CNT_W-1:0] LEN_TEST  = CNT_W'(TEST_W);
  localparam logic [ONES_W-1:0] ONES_LAST = ONES_W'(ONES_LIMIT - 1);

  ifState_t          state;
  logic [6:0]        commSh;
  logic [2:0]        commCnt;
  logic [CNT_W-1:0]  bitCnt, xferLen, newLen;
  logic [2:0]        selQ;
  logic [1:0]        pairQ;
  logic [ONES_W-1:0] onesCnt;

  logic       strobe, resync, commDone, commValid, calBlocked, startXfer, lastBit;
  logic [7:0] commByte;

  assign strobe     = shiftEn & ~csN;
  assign resync     = strobe & sdi & (onesCnt == ONES_LAST);
  assign commByte   = {commSh, sdi};
  assign commDone   = strobe & ~resync & (state == ST_WAIT) & (commCnt == 3'd7);
  assign commValid  = commDone & ~commByte[7] & commByte[6];
  assign calBlocked = commValid & (commByte[6:5] == 2'b11) & calBusy;
  assign startXfer  = commValid & ~calBlocked;
  assign lastBit    = strobe & ~resync & (state != ST_WAIT) & (bitCnt == xferLen - 1'b1);

  always_comb begin
    case (commByte[6:4])
      SEL_TEST: newLen = LEN_TEST;
      SEL_DATA: newLen = wordLen24 ? LEN_CAL : LEN_SHORT;
      default:  newLen = LEN_CAL;
    endcase
  end

  always_comb begin
    ctl            = '0;
    ctl.sel        = (state == ST_WAIT) ? commByte[6:4] : selQ;
    ctl.pair       = (state == ST_WAIT) ? commByte[1:0] : pairQ;
    ctl.loadRead   = startXfer & commByte[3];
    ctl.shiftOut   = strobe & ~resync & (state == ST_READ);
    ctl.shiftIn    = strobe & ~resync & (state == ST_WRITE);
    ctl.commitTest = lastBit & (state == ST_WRITE) & (selQ == SEL_TEST);
    ctl.commitZs   = lastBit & (state == ST_WRITE) & (selQ == SEL_ZS);
    ctl.commitFs   = lastBit & (state == ST_WRITE) & (selQ == SEL_FS);
  end

  assign reading = (state == ST_READ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAIT;
      commSh  <= '0;
      commCnt <= '0;
      bitCnt  <= '0;
      xferLen <= '0;
      selQ    <= '0;
      pairQ   <= '0;
      onesCnt <= '0;
    end else if (csN) begin
      state   <= ST_WAIT;
      commCnt <= '0;
      bitCnt  <= '0;
      onesCnt <= '0;
    end else if (strobe) begin
      onesCnt <= sdi ? onesCnt + 1'b1 : '0;
      if (resync) begin
        state   <= ST_WAIT;
        commCnt <= '0;
        bitCnt  <= '0;
        onesCnt <= '0;
      end else if (state == ST_WAIT) begin
        commSh  <= commByte[6:0];
        commCnt <= commCnt + 1'b1;
        if (startXfer) begin
          state   <= commByte[3] ? ST_READ : ST_WRITE;
          selQ    <= commByte[6:4];
          pairQ   <= commByte[1:0];
          xferLen <= newLen;
          bitCnt  <= '0;
        end
      end else if (lastBit) begin
        state  <= ST_WAIT;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           calErr <= 1'b0;
    else if (calBlocked) calErr <= 1'b1;
  end

  assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (state == ST_WAIT && bitCnt == '0 && commCnt == '0));
  assert_resync_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> (state == ST_WAIT && onesCnt == '0 && commCnt == '0));
  assert_commit_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.commitTest, ctl.commitZs, ctl.commitFs}));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    calErr |=> calErr);
  assert_busy_noxfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    calBlocked |=> (calErr && state == ST_WAIT));
endmodule

// File: rtl/adc_if_dp.sv
module adc_if_dp
  import adc_if_pkg::*;
#(
  parameter int          CAL_W     = 24,
  parameter int          TEST_W    = 8,
  parameter int          NUM_PAIRS = 3,
  parameter logic [23:0] ZS_RST    = 24'h1F4000,
  parameter logic [23:0] FS_RST    = 24'h5761AB
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             sdi,
  input  logic             reading,
  input  logic [CAL_W-1:0] convData,
  output logic             sdo,
  output logic             testMode
);
  localparam int PIDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam logic [PIDX_W-1:0] PAIR_MAX = PIDX_W'(NUM_PAIRS - 1);

  logic [CAL_W-2:0]  writeShift;
  logic [CAL_W-1:0]  wordIn, readShift, readVal;
  logic [TEST_W-1:0] testReg;
  logic [CAL_W-1:0]  zsReg [NUM_PAIRS];
  logic [CAL_W-1:0]  fsReg [NUM_PAIRS];
  logic [PIDX_W-1:0] pairIdx;

  assign wordIn  = {writeShift, sdi};
  assign pairIdx = (int'(ctl.pair) >= NUM_PAIRS) ? PAIR_MAX : PIDX_W'(ctl.pair);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            writeShift <= '0;
    else if (ctl.shiftIn) writeShift <= wordIn[CAL_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               testReg <= '0;
    else if (ctl.commitTest) testReg <= wordIn[TEST_W-1:0];
  end

  assign testMode = |testReg;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        zsReg[p] <= CAL_W'(ZS_RST);
        fsReg[p] <= CAL_W'(FS_RST);
      end else begin
        if (ctl.commitZs && pairIdx == PIDX_W'(p)) zsReg[p] <= wordIn;
        if (ctl.commitFs && pairIdx == PIDX_W'(p)) fsReg[p] <= wordIn;
      end
    end

    assert_zs_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      !(ctl.commitZs && pairIdx == PIDX_W'(p)) |=> $stable(zsReg[p]));
    assert_fs_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      !(ctl.commitFs && pairIdx == PIDX_W'(p)) |=> $stable(fsReg[p]));
  end

  always_comb begin
    case (ctl.sel)
      SEL_TEST: readVal = {testReg, {(CAL_W - TEST_W){1'b0}}};
      SEL_DATA: readVal = convData;
      SEL_ZS:   readVal = zsReg[pairIdx];
      SEL_FS:   readVal = fsReg[pairIdx];
      default:  readVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             readShift <= '0;
    else if (ctl.loadRead) readShift <= readVal;
    else if (ctl.shiftOut) readShift <= {readShift[CAL_W-2:0], 1'b0};
  end

  assign sdo = reading & readShift[CAL_W-1];

  assert_test_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commitTest |=> $stable(testReg));
  assert_sdo_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadRead && !ctl.shiftOut |=> $stable(readShift));
endmodule

// File: rtl/adc_serial_regif.sv
module adc_serial_regif
  import adc_if_pkg::*;
#(
  parameter int          CAL_W      = 24,
  parameter int          SHORT_W    = 16,
  parameter int          TEST_W     = 8,
  parameter int          NUM_PAIRS  = 3,
  parameter int          ONES_LIMIT = 32,
  parameter logic [23:0] ZS_RST     = 24'h1F4000,
  parameter logic [23:0] FS_RST     = 24'h5761AB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             shiftEn,
  input  logic             sdi,
  output logic             sdo,
  input  logic             wordLen24,
  input  logic             calBusy,
  input  logic [CAL_W-1:0] convData,
  output logic             testMode,
  output logic             calErr
);
  dpCtl_t ctl;
  logic   reading;

  adc_if_ctrl #(
    .CAL_W(CAL_W), .SHORT_W(SHORT_W), .TEST_W(TEST_W), .ONES_LIMIT(ONES_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .shiftEn(shiftEn), .sdi(sdi),
    .wordLen24(wordLen24), .calBusy(calBusy),
    .ctl(ctl), .reading(reading), .calErr(calErr)
  );

  adc_if_dp #(
    .CAL_W(CAL_W), .TEST_W(TEST_W), .NUM_PAIRS(NUM_PAIRS),
    .ZS_RST(ZS_RST), .FS_RST(FS_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdi(sdi), .reading(reading),
    .convData(convData), .sdo(sdo), .testMode(testMode)
  );
endmodule

// File: tb/adc_serial_regif_bench.sv
`timescale 1ns/1ps
module adc_serial_regif_bench;
  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, shiftEn = 1'b0, sdi = 1'b0;
  logic wordLen24 = 1'b1, calBusy = 1'b0;
  logic [23:0] convData = 24'hC3A55A;
  logic sdo, testMode, calErr;
  int nRun = 0, nFail = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_serial_regif u_adc_serial_regif (
    .clk(clk), .rstN(rstN), .csN(csN), .shiftEn(shiftEn), .sdi(sdi), .sdo(sdo),
    .wordLen24(wordLen24), .calBusy(calBusy), .convData(convData),
    .testMode(testMode), .calErr(calErr)
  );

  // behavioural reference model
  int mSt = 0, mCc = 0, mCnt = 0, mLen = 0, mOnes = 0, mSel = 0, mPair = 0;
  logic [7:0]  mComm = '0;
  logic [23:0] mAcc = '0, mRd = '0;
  logic [7:0]  mTest = '0;
  logic [23:0] mZs [3], mFs [3];
  logic        mErr = 0;

  function automatic logic [23:0] curVal(int sel, int pr);
    case (sel)
      4: return {mTest, 16'h0};
      5: return convData;
      6: return mZs[pr];
      default: return mFs[pr];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCc = 0; mCnt = 0; mOnes = 0; mTest = '0; mErr = 0; mComm = '0;
      for (int i = 0; i < 3; i++) begin mZs[i] = 24'h1F4000; mFs[i] = 24'h5761AB; end
    end else if (csN) begin
      mSt = 0; mCc = 0; mCnt = 0; mOnes = 0;
    end else if (shiftEn) begin
      mOnes = sdi ? mOnes + 1 : 0;
      if (mOnes == 32) begin
        mSt = 0; mCc = 0; mCnt = 0; mOnes = 0;
      end else if (mSt == 0) begin
        mComm = {mComm[6:0], sdi};
        mCc++;
        if (mCc == 8) begin
          mCc = 0;
          if (!mComm[7] && mComm[6]) begin
            mSel = int'(mComm[6:4]);
            mPair = (mComm[1:0] == 2'd3) ? 2 : int'(mComm[1:0]);
            if (mSel >= 6 && calBusy) mErr = 1;
            else begin
              mLen = (mSel == 4) ? 8 : (mSel == 5 && !wordLen24) ? 16 : 24;
              mCnt = 0; mAcc = '0;
              if (mComm[3]) begin mSt = 2; mRd = curVal(mSel, mPair); end
              else mSt = 1;
            end
          end
        end
      end else begin
        mAcc = {mAcc[22:0], sdi};
        mCnt++;
        if (mCnt == mLen) begin
          if (mSt == 1) begin
            if (mSel == 4) mTest = mAcc[7:0];
            else if (mSel == 6) mZs[mPair] = mAcc;
            else if (mSel == 7) mFs[mPair] = mAcc;
          end
          mSt = 0; mCnt = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic eSdo;
      eSdo = (mSt == 2) ? mRd[23 - mCnt] : 1'b0;
      nRun++;
      if (sdo !== eSdo || testMode !== (mTest != 0) || calErr !== mErr) begin
        nFail++;
        $display("FAIL per-cycle R1 R3 R8 R9: sdo/testMode/calErr=%b%b%b expected %b%b%b",
                 sdo, testMode, calErr, eSdo, (mTest != 0), mErr);
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      finishRun();
    end
  end

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd(logic [2:0] sel, logic rd, logic [1:0] pr);
    return {1'b0, sel, rd, 1'b0, pr};
  endfunction

  task automatic sendBit(logic b);
    @(negedge clk); sdi = b; shiftEn = 1'b1;
    @(negedge clk); shiftEn = 1'b0;
  endtask

  task automatic sendBits(logic [23:0] v, int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic readReg(logic [7:0] c, int n, output logic [23:0] v);
    sendBits({16'h0, c}, 8);
    v = '0;
    for (int i = 0; i < n; i++) begin
      v = {v[22:0], sdo};
      sendBit(1'b0);
    end
  endtask

  task automatic csPulse();
    @(negedge clk); csN = 1'b1;
    @(negedge clk); csN = 1'b0;
  endtask

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 sdo", {23'h0, sdo}, 24'h0);
    chk("R1 testMode", {23'h0, testMode}, 24'h0);
    chk("R1 calErr", {23'h0, calErr}, 24'h0);
    csN = 1'b0;
    readReg(cmd(3'b110, 1, 0), 24, v); chk("R1 offset reset", v, 24'h1F4000);
    readReg(cmd(3'b111, 1, 1), 24, v); chk("R1 gain reset", v, 24'h5761AB);
    readReg(cmd(3'b100, 1, 0), 8, v);  chk("R1 test reset", v, 24'h0);

    // R4 calibration writes
    sendBits({16'h0, cmd(3'b110, 0, 1)}, 8); sendBits(24'h123456, 24);
    readReg(cmd(3'b110, 1, 1), 24, v); chk("R4 offset pair1", v, 24'h123456);
    readReg(cmd(3'b110, 1, 0), 24, v); chk("R4 offset pair0 untouched", v, 24'h1F4000);
    sendBits({16'h0, cmd(3'b111, 0, 3)}, 8); sendBits(24'hABCDEF, 24);
    readReg(cmd(3'b111, 1, 2), 24, v); chk("R4 pair code 3 -> pair2", v, 24'hABCDEF);

    // R6 partial write abandoned
    sendBits({16'h0, cmd(3'b110, 0, 0)}, 8); sendBits(24'hFFF, 12);
    csPulse();
    readReg(cmd(3'b110, 1, 0), 24, v); chk("R6 abort keeps offset", v, 24'h1F4000);
    sendBits(24'h5, 3); csPulse();
    readReg(cmd(3'b111, 1, 0), 24, v); chk("R6 partial command dropped", v, 24'h5761AB);

    // R3 result reads
    wordLen24 = 1'b0;
    readReg(cmd(3'b101, 1, 0), 16, v); chk("R3 16-bit result", v, 24'h00C3A5);
    wordLen24 = 1'b1; convData = 24'h3C0FF1;
    readReg(cmd(3'b101, 1, 0), 24, v); chk("R3 24-bit result", v, 24'h3C0FF1);

    // R5 result writes consumed then dropped
    wordLen24 = 1'b0;
    sendBits({16'h0, cmd(3'b101, 0, 0)}, 8); sendBits(24'h00A5A5, 16);
    readReg(cmd(3'b111, 1, 1), 24, v); chk("R5 framing after 16-bit write", v, 24'h5761AB);
    wordLen24 = 1'b1;
    sendBits({16'h0, cmd(3'b101, 0, 0)}, 8); sendBits(24'h5A5A5A, 24);
    readReg(cmd(3'b110, 1, 1), 24, v); chk("R5 framing after 24-bit write", v, 24'h123456);

    // R2 ignored command bytes
    sendBits(24'hE8, 8); sendBits({16'h0, cmd(3'b001, 0, 0)}, 8);
    readReg(cmd(3'b111, 1, 2), 24, v); chk("R2 ignored bytes", v, 24'hABCDEF);

    // R8 test register
    sendBits({16'h0, cmd(3'b100, 0, 0)}, 8); sendBits(24'h5A, 8);
    @(negedge clk); chk("R8 testMode set", {23'h0, testMode}, 24'h1);
    readReg(cmd(3'b100, 1, 0), 8, v); chk("R8 test readback", v, 24'h5A);

    // R7 resync from a misaligned position
    sendBits(24'h0, 3);
    for (int i = 0; i < 32; i++) sendBit(1'b1);
    sendBits({16'h0, cmd(3'b100, 0, 0)}, 8); sendBits(24'h00, 8);
    @(negedge clk); chk("R7 R8 resync then zero clears testMode", {23'h0, testMode}, 24'h0);
    readReg(cmd(3'b110, 1, 1), 24, v); chk("R7 aligned after resync", v, 24'h123456);

    // R9 refused calibration access
    calBusy = 1'b1;
    sendBits({16'h0, cmd(3'b110, 0, 0)}, 8);
    @(negedge clk); chk("R9 calErr set", {23'h0, calErr}, 24'h1);
    calBusy = 1'b0;
    readReg(cmd(3'b110, 1, 0), 24, v); chk("R9 refused access no transfer", v, 24'h1F4000);
    chk("R9 calErr sticky", {23'h0, calErr}, 24'h1);

    // R10 strobes with select high
    @(negedge clk); csN = 1'b1;
    for (int i = 0; i < 20; i++) sendBit(i[0]);
    @(negedge clk); csN = 1'b0;
    readReg(cmd(3'b111, 1, 1), 24, v); chk("R10 deselected strobes ignored", v, 24'h5761AB);
    readReg(cmd(3'b100, 1, 0), 8, v);  chk("R10 test unchanged", v, 24'h0);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule